// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two component predictors run side by side. The global component keeps a shift register of the most recent branch outcomes and uses it to index a table of 2-bit saturating counters. The local component first reads a per-address history of that branch's own recent outcomes. It then uses that history to index a table of 3-bit saturating counters. A third table of 2-bit counters acts as the chooser. Each chooser entry records which component has recently been more reliable, and so decides which of the two guesses becomes the final prediction.

The fetch side is purely combinational. It takes a branch address and, in the same cycle, returns the final direction, both component guesses and the chooser's selection. The resolve side takes the branch address, the actual outcome and the two component guesses recorded at fetch. At the next clock edge it trains the counters and both histories. Histories are updated only at resolve. Table sizes are parameters, and the defaults give a 12-bit global history, 4096-entry global and chooser tables, 1024 local histories of 10 bits and 1024 local counters.

Top module: `tourney_bpred`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears every history to zero. It sets every 2-bit global counter to 1, every 3-bit local counter to 3 and every chooser entry to 1. After reset, any address therefore fetches `pred_global`=0, `pred_local`=0, `use_local`=0 and `pred_taken`=0.
- R2: `pred_taken` equals `pred_local` when `use_local` is 1 and equals `pred_global` otherwise. `use_local` is 1 when the chooser entry selected by the current global history holds 2 or more.
- R3: The global history is 12 bits. On each resolve, the actual outcome (1 = taken) enters bit 0 and the older bits move up by one. The global counter table is indexed by the global history, and `pred_global` is 1 when the selected counter is 2 or more.
- R4: The local history table is indexed by address bits [11:2], and each entry holds 10 outcome bits. On resolve, the outcome enters bit 0 of the entry for `res_pc`. That entry's history, read before the shift, selects the 3-bit local counter that is trained. `pred_local` is 1 when the local counter selected by the fetch address's history is 4 or more.
- R5: On resolve, the counter that trains is incremented when the branch was taken and decremented when it was not. The counter that trains is the global one selected by the global history before the shift, and the local one selected as in R4. A 2-bit counter saturates at 0 and 3, and a 3-bit counter saturates at 0 and 7.
- R6: The chooser entry selected by the pre-shift global history trains only when `res_pred_global` differs from `res_pred_local`. It increments (toward local) when `res_pred_local` matches the outcome and decrements otherwise, saturating at 0 and 3.
- R7: Fetch outputs depend only on `fetch_pc` and state held before the current edge. A resolve in the same cycle affects fetch outputs only from the next cycle on.
- R8: When `res_valid` is 0, no history, counter or chooser entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | 32 | Address of the branch being predicted |
| pred_taken | output | 1 | Final direction guess |
| pred_global | output | 1 | Global component guess |
| pred_local | output | 1 | Local component guess |
| use_local | output | 1 | Chooser picks the local component |
| res_valid | input | 1 | A branch outcome is being reported |
| res_pc | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| res_pred_global | input | 1 | Global guess recorded at fetch |
| res_pred_local | input | 1 | Local guess recorded at fetch |

## Verification
The bench first drives a single address that is always taken. This pushes both histories to all ones and drives the counters into their upper saturation, which separates correct saturation from wrap-around. It then holds resolve idle while the fetch address sweeps. This shows that idle cycles leave every table untouched and that the local prediction follows the address bits [11:2]. A long run with several addresses, each repeating its own periodic outcome pattern and resolved in the same cycle it is fetched, makes the two components disagree often. That exercises chooser training in both directions, the agreement case that must not train, and the rule that a same-cycle resolve is not seen by fetch.

// File: rtl/tbp_pkg.sv
// Package: shared helper for the tournament predictor.
// Assumes counters are at most 8 bits wide.
package tbp_pkg;

    // Saturating step of an unsigned counter between 0 and maxv.
    function automatic logic [7:0] sat_step(input logic [7:0] v,
                                            input logic [7:0] maxv,
                                            input logic       up);
        logic [7:0] r;
        r = v;
        if (up && v != maxv)
            r = v + 8'd1;
        else if (!up && v != 8'd0)
            r = v - 8'd1;
        return r;
    endfunction

endpackage

// File: rtl/tbp_ctr_table.sv
// Module: table of saturating counters with one combinational read port
// and one clocked update port. Used for the global, local and chooser tables.
// Assumes a synchronous active-low reset that loads RST_VAL into every entry.
module tbp_ctr_table #(
    parameter int IDX_W   = 12,
    parameter int CTR_W   = 2,
    parameter int RST_VAL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_val,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_up
);
    import tbp_pkg::*;

    localparam int DEPTH = 1 << IDX_W;
    localparam int MAXV  = (1 << CTR_W) - 1;

    logic [CTR_W-1:0] mem [DEPTH];

    // Read port: combinational lookup.
    assign rd_val = mem[rd_idx];

    // Reset every counter, otherwise step the addressed counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= CTR_W'(RST_VAL);
        end else if (upd_en) begin
            mem[upd_idx] <= CTR_W'(sat_step(8'(mem[upd_idx]), 8'(MAXV), upd_up));
        end
    end

    AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && upd_up |=> mem[$past(upd_idx)] >= $past(mem[upd_idx])); // R5
    AST_NO_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && !upd_up |=> mem[$past(upd_idx)] <= $past(mem[upd_idx])); // R5

endmodule

// File: rtl/tbp_local_hist.sv
// Module: per-address outcome history table with two read ports
// (fetch and resolve) and a shift-in write at the resolve address.
// Assumes the resolve read port also addresses the write.
module tbp_local_hist #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  f_idx,
    output logic [HIST_W-1:0] f_hist,
    input  logic [IDX_W-1:0]  r_idx,
    output logic [HIST_W-1:0] r_hist,
    input  logic              wr_en,
    input  logic              wr_bit
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] hist [DEPTH];

    // Read ports: combinational.
    assign f_hist = hist[f_idx];
    assign r_hist = hist[r_idx];

    // Clear all histories on reset, otherwise shift the outcome in at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                hist[i] <= '0;
        end else if (wr_en) begin
            hist[r_idx] <= {hist[r_idx][HIST_W-2:0], wr_bit};
        end
    end

    AST_LHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> hist[$past(r_idx)] ==
                  {$past(hist[r_idx][HIST_W-2:0]), $past(wr_bit)}); // R4

endmodule

// File: rtl/tourney_bpred.sv
// Module: tournament direction predictor. A global-history counter table and
// a two-level local predictor run in parallel; a chooser table indexed by the
// global history selects between them. Fetch is combinational; resolve trains
// the tables and histories at the next edge.
// Assumes the resolve side returns the component guesses recorded at fetch and
// that histories are non-speculative (updated at resolve only).
module tourney_bpred #(
    parameter int PC_W    = 32,
    parameter int GHIST_W = 12,
    parameter int LIDX_W  = 10,
    parameter int LHIST_W = 10,
    parameter int GCTR_W  = 2,
    parameter int LCTR_W  = 3,
    parameter int CH_W    = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_taken,
    output logic            pred_global,
    output logic            pred_local,
    output logic            use_local,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic            res_pred_global,
    input  logic            res_pred_local
);
    // Counter reset values: weakly not-taken, chooser weakly global.
    localparam int GCTR_RST = (1 << (GCTR_W - 1)) - 1;
    localparam int LCTR_RST = (1 << (LCTR_W - 1)) - 1;
    localparam int CH_RST   = (1 << (CH_W - 1)) - 1;
    localparam int LIDX_LO  = 2;
    localparam int LIDX_HI  = LIDX_LO + LIDX_W - 1;

    logic [GHIST_W-1:0] ghist;
    logic [GCTR_W-1:0]  g_ctr;
    logic [LCTR_W-1:0]  l_ctr;
    logic [CH_W-1:0]    ch_ctr;
    logic [LHIST_W-1:0] f_lhist;
    logic [LHIST_W-1:0] r_lhist;
    logic               ch_upd;

    // Global history: shift the resolved outcome in at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ghist <= '0;
        else if (res_valid)
            ghist <= {ghist[GHIST_W-2:0], res_taken};
    end

    tbp_local_hist #(.IDX_W(LIDX_W), .HIST_W(LHIST_W)) u_lhist (
        .clk    (clk),
        .rst_n  (rst_n),
        .f_idx  (fetch_pc[LIDX_HI:LIDX_LO]),
        .f_hist (f_lhist),
        .r_idx  (res_pc[LIDX_HI:LIDX_LO]),
        .r_hist (r_lhist),
        .wr_en  (res_valid),
        .wr_bit (res_taken)
    );

    tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W), .RST_VAL(GCTR_RST)) u_gtab (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (ghist),
        .rd_val  (g_ctr),
        .upd_en  (res_valid),
        .upd_idx (ghist),
        .upd_up  (res_taken)
    );

    tbp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W), .RST_VAL(LCTR_RST)) u_ltab (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (f_lhist),
        .rd_val  (l_ctr),
        .upd_en  (res_valid),
        .upd_idx (r_lhist),
        .upd_up  (res_taken)
    );

    // Chooser trains only when the recorded component guesses disagree.
    assign ch_upd = res_valid && (res_pred_global != res_pred_local);

    tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(CH_W), .RST_VAL(CH_RST)) u_chooser (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (ghist),
        .rd_val  (ch_ctr),
        .upd_en  (ch_upd),
        .upd_idx (ghist),
        .upd_up  (res_pred_local == res_taken)
    );

    // Final selection: counter MSB gives each direction and the choice.
    always_comb begin
        pred_global = g_ctr[GCTR_W-1];
        pred_local  = l_ctr[LCTR_W-1];
        use_local   = ch_ctr[CH_W-1];
        pred_taken  = use_local ? pred_local : pred_global;
    end

    AST_GHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> ghist == {$past(ghist[GHIST_W-2:0]), $past(res_taken)}); // R3
    AST_GHIST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(ghist)); // R8

endmodule

// File: tb/test_tourney_bpred.sv
module test_tourney_bpred;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_taken, pred_global, pred_local, use_local;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic        res_pred_global = 1'b0;
    logic        res_pred_local = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Behavioural reference state.
    int gt [4096];
    int lt [1024];
    int ch [4096];
    int lh [1024];
    int gh;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tourney_bpred i_tourney_bpred (
        .clk             (clk),
        .rst_n           (rst_n),
        .fetch_pc        (fetch_pc),
        .pred_taken      (pred_taken),
        .pred_global     (pred_global),
        .pred_local      (pred_local),
        .use_local       (use_local),
        .res_valid       (res_valid),
        .res_pc          (res_pc),
        .res_taken       (res_taken),
        .res_pred_global (res_pred_global),
        .res_pred_local  (res_pred_local)
    );

    function automatic int sat(int v, int maxv, bit up);
        if (up) return (v < maxv) ? v + 1 : v;
        return (v > 0) ? v - 1 : v;
    endfunction

    function automatic bit m_glob();
        return gt[gh] >= 2;
    endfunction
    function automatic bit m_loc(logic [31:0] pc);
        return lt[lh[(pc >> 2) & 1023]] >= 4;
    endfunction
    function automatic bit m_sel();
        return ch[gh] >= 2;
    endfunction

    task automatic model_reset();
        foreach (gt[i]) gt[i] = 1;
        foreach (ch[i]) ch[i] = 1;
        foreach (lt[i]) lt[i] = 3;
        foreach (lh[i]) lh[i] = 0;
        gh = 0;
    endtask

    // Apply one resolve to the reference state (post-edge view).
    task automatic model_resolve(logic [31:0] pc, bit t, bit rg, bit rl);
        int li;
        li = (pc >> 2) & 1023;
        gt[gh] = sat(gt[gh], 3, t);
        lt[lh[li]] = sat(lt[lh[li]], 7, t);
        if (rg != rl) ch[gh] = sat(ch[gh], 3, rl == t);
        lh[li] = ((lh[li] << 1) | int'(t)) & 1023;
        gh = ((gh << 1) | int'(t)) & 4095;
    endtask

    task automatic check(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s got %0d exp %0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    // Compare all fetch outputs with the reference (current pre-edge state).
    task automatic compare(string tag);
        bit eg, el, es;
        eg = m_glob();
        el = m_loc(fetch_pc);
        es = m_sel();
        check({tag, "/R3"}, "pred_global", pred_global, eg);
        check({tag, "/R4"}, "pred_local", pred_local, el);
        check({tag, "/R6"}, "use_local", use_local, es);
        check({tag, "/R2"}, "pred_taken", pred_taken, es ? el : eg);
    endtask

    // One cycle: drive at negedge, compare, then model the edge.
    // With do_res, the branch fetched this cycle is resolved in the same cycle
    // using the component guesses the reference expects (R7).
    task automatic step(string tag, logic [31:0] pc, bit do_res, bit t);
        bit rg, rl;
        @(negedge clk);
        rg = m_glob();
        rl = m_loc(pc);
        fetch_pc        = pc;
        res_valid       = do_res;
        res_pc          = pc;
        res_taken       = t;
        res_pred_global = rg;
        res_pred_local  = rl;
        #1;
        compare(tag);
        if (do_res) model_resolve(pc, t, rg, rl);
        @(posedge clk);
    endtask

    initial begin : watchdog
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        int cnt [8];
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        fetch_pc = 32'h0000_1234;
        #1;
        // R1: reset state seen at the fetch port.
        check("R1", "pred_global", pred_global, 0);
        check("R1", "pred_local", pred_local, 0);
        check("R1", "use_local", use_local, 0);
        check("R1", "pred_taken", pred_taken, 0);

        // R5: always-taken branch drives counters to upper saturation.
        for (int i = 0; i < 30; i++) step("R5", 32'h0000_0040, 1'b1, 1'b1);
        @(negedge clk);
        res_valid = 1'b0;
        fetch_pc = 32'h0000_0040;
        #1;
        check("R5", "saturated pred_global", pred_global, 1);
        check("R5", "saturated pred_local", pred_local, 1);
        // Then not-taken drives them down to lower saturation.
        for (int i = 0; i < 30; i++) step("R5", 32'h0000_0040, 1'b1, 1'b0);

        // R8: idle resolve port, sweeping fetch addresses (R4 index bits).
        for (int i = 0; i < 40; i++) step("R8", 32'h0000_0040 + 32'(i * 4), 1'b0, 1'b0);
        step("R8", 32'h0000_1040, 1'b0, 1'b0);

        // R6/R7: mixed addresses, each with its own periodic pattern.
        foreach (cnt[k]) cnt[k] = 0;
        for (int i = 0; i < 4000; i++) begin
            int k;
            bit t;
            k = int'($urandom_range(0, 7));
            t = (cnt[k] % (k + 2)) != 0;
            cnt[k]++;
            step("R7", 32'h0000_0100 + 32'(k * 36), 1'b1, t);
            if (i % 16 == 0) step("R8", 32'h0000_0100 + 32'(k * 36), 1'b0, 1'b0);
        end

        // R1: reset again mid-run restores the initial state.
        @(negedge clk);
        rst_n = 1'b0;
        res_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
        check("R1", "use_local after reset", use_local, 0);
        check("R1", "pred_taken after reset", pred_taken, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule